// File: doc/BRIEF.md
# Gate Edge Delay with Safe-State Override

This block conditions one PWM bit before it drives a power switch gate. It delays one chosen transition of the incoming bit by a programmable number of clock cycles. The opposite transition passes through with no added delay. This gives the switch a turn-on delay while its turn-off stays prompt. The edge that is delayed is selectable, so the same block serves switches that conduct on a low gate level.

The delay comes from one of two sources. It is either a fixed count, or a variable count that is raised to a configured floor when the request falls below it. A pending delayed transition is dropped if the input returns to its old level before the count runs out, so a pulse shorter than the delay never reaches the gate. A protection trip forces the output to a configured safe level at the next clock edge, and so does a low run enable. The safe level is also driven combinationally while reset is held. When the override is removed, the output starts from the safe level, and the next delayed transition waits the full count.

Top module: `pwm_turnon_delay`

## Requirements
- R1: While `rst_n` is low, `gate_o` equals `safe_lvl_i`.
- R2: With `edge_sel_i` = 1, a rising `pwm_i` first sampled at clock edge k makes `gate_o` rise at edge k+D, where D is the effective delay. D = 0 gives a rise at edge k.
- R3: With `edge_sel_i` = 1, a falling `pwm_i` first sampled at edge k makes `gate_o` fall at edge k.
- R4: With `edge_sel_i` = 0, the roles are swapped. A falling input is delayed by D cycles and a rising input passes at edge k.
- R5: With `var_mode_i` = 0, the effective delay is `fix_dly_i`, and `var_dly_i` and `min_dly_i` are ignored.
- R6: With `var_mode_i` = 1, the effective delay is the larger of `var_dly_i` and `min_dly_i`.
- R7: If `pwm_i` returns to the level of `gate_o` before a pending delay expires, the pending change is cancelled and `gate_o` does not change.
- R8: `trip_i` high at an edge sets `gate_o` to `safe_lvl_i` at that edge, whatever the value of `edge_sel_i`. The output is held there while `trip_i` stays high.
- R9: `run_i` low at an edge sets `gate_o` to `safe_lvl_i` at that edge, in the same way as a trip.
- R10: After the override is removed, `gate_o` starts from the safe level. An input level that differs from it in the delayed direction waits the full delay. One that differs in the other direction passes at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwm_i | input | 1 | Raw PWM bit |
| var_mode_i | input | 1 | 1 selects the clamped variable delay, 0 selects the fixed delay |
| fix_dly_i | input | DLY_W | Fixed delay in clock cycles |
| var_dly_i | input | DLY_W | Requested variable delay in clock cycles |
| min_dly_i | input | DLY_W | Floor for the variable delay |
| edge_sel_i | input | 1 | 1 delays rising transitions, 0 delays falling transitions |
| safe_lvl_i | input | 1 | Output level forced during override |
| trip_i | input | 1 | Protection trip, active high |
| run_i | input | 1 | Run enable, active high |
| gate_o | output | 1 | Conditioned gate bit |

## Verification
The hardest case to reach is an override that arrives in the middle of a pending delay, followed by a release where the input already differs from the safe level. The release must then be treated as a fresh transition that waits the full count. The bench holds the input high through a trip. It releases the trip with the safe level at 0 and checks that the rise takes the whole delay. It then releases a low run enable with the input low and the safe level at 1, and expects an immediate fall. Cancellation is reached by a pulse that is shorter than the programmed delay, and the output is then watched for longer than the delay.

// File: rtl/pwm_turnon_delay_pkg.sv
package pwm_turnon_delay_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_e;

    localparam int unsigned DEF_CLK_MHZ    = 100;
    localparam int unsigned DEF_MAX_DLY_US = 400;

endpackage

// File: rtl/pwm_dly_sel.sv
module pwm_dly_sel #(
    parameter int unsigned DLY_W = 16
) (
    input  logic             var_mode_i,
    input  logic [DLY_W-1:0] fix_dly_i,
    input  logic [DLY_W-1:0] var_dly_i,
    input  logic [DLY_W-1:0] min_dly_i,
    output logic [DLY_W-1:0] dly_o
);

    logic [DLY_W-1:0] clamped;

    always_comb begin
        clamped = (var_dly_i < min_dly_i) ? min_dly_i : var_dly_i;
        dly_o   = var_mode_i ? clamped : fix_dly_i;
    end

endmodule

// File: rtl/pwm_dly_edge.sv
module pwm_dly_edge
    import pwm_turnon_delay_pkg::*;
#(
    parameter int unsigned DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_i,
    input  logic [DLY_W-1:0] dly_i,
    input  edge_e            edge_sel_i,
    input  logic             ovr_i,
    input  logic             safe_lvl_i,
    output logic             lvl_o
);

    typedef struct packed {
        logic             lvl;
        logic             pend;
        logic [DLY_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic is_active;

    always_comb begin
        st_d      = st_q;
        is_active = (pwm_i == logic'(edge_sel_i));
        if (ovr_i) begin
            st_d.lvl  = safe_lvl_i;
            st_d.pend = 1'b0;
            st_d.cnt  = '0;
        end else if (pwm_i == st_q.lvl) begin
            st_d.pend = 1'b0;
        end else if (!is_active) begin
            st_d.lvl  = pwm_i;
            st_d.pend = 1'b0;
        end else if (!st_q.pend) begin
            if (dly_i == '0) begin
                st_d.lvl = pwm_i;
            end else begin
                st_d.pend = 1'b1;
                st_d.cnt  = dly_i - 1'b1;
            end
        end else if (st_q.cnt == '0) begin
            st_d.lvl  = pwm_i;
            st_d.pend = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

endmodule

// File: rtl/pwm_turnon_delay.sv
module pwm_turnon_delay
    import pwm_turnon_delay_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = DEF_CLK_MHZ,
    parameter int unsigned MAX_DLY_US = DEF_MAX_DLY_US,
    localparam int unsigned CNT_MAX   = CLK_MHZ * MAX_DLY_US,
    localparam int unsigned DLY_W     = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_i,
    input  logic             var_mode_i,
    input  logic [DLY_W-1:0] fix_dly_i,
    input  logic [DLY_W-1:0] var_dly_i,
    input  logic [DLY_W-1:0] min_dly_i,
    input  logic             edge_sel_i,
    input  logic             safe_lvl_i,
    input  logic             trip_i,
    input  logic             run_i,
    output logic             gate_o
);

    logic [DLY_W-1:0] eff_dly;
    logic             ovr;
    logic             lvl;

    assign ovr = trip_i | ~run_i;

    pwm_dly_sel #(.DLY_W(DLY_W)) u_sel (
        .var_mode_i (var_mode_i),
        .fix_dly_i  (fix_dly_i),
        .var_dly_i  (var_dly_i),
        .min_dly_i  (min_dly_i),
        .dly_o      (eff_dly)
    );

    pwm_dly_edge #(.DLY_W(DLY_W)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_i      (pwm_i),
        .dly_i      (eff_dly),
        .edge_sel_i (edge_e'(edge_sel_i)),
        .ovr_i      (ovr),
        .safe_lvl_i (safe_lvl_i),
        .lvl_o      (lvl)
    );

    assign gate_o = rst_n ? lvl : safe_lvl_i;

endmodule

// File: rtl/pwm_turnon_delay_chk.sv
module pwm_turnon_delay_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_i,
    input logic edge_sel_i,
    input logic safe_lvl_i,
    input logic trip_i,
    input logic run_i,
    input logic gate_o
);

    a_r8_trip_safe: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> gate_o == $past(safe_lvl_i));

    a_r9_norun_safe: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> gate_o == $past(safe_lvl_i));

    a_r3_fall_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !trip_i && edge_sel_i && !pwm_i) |=> !gate_o);

    a_r4_rise_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !trip_i && !edge_sel_i && pwm_i) |=> gate_o);

    a_r7_follow_only: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !trip_i) |=> (gate_o == $past(gate_o) || gate_o == $past(pwm_i)));

endmodule

bind pwm_turnon_delay pwm_turnon_delay_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_i      (pwm_i),
    .edge_sel_i (edge_sel_i),
    .safe_lvl_i (safe_lvl_i),
    .trip_i     (trip_i),
    .run_i      (run_i),
    .gate_o     (gate_o)
);

// File: tb/tb_pwm_turnon_delay.sv
module tb_pwm_turnon_delay;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwm_i = 1'b0;
    logic         var_mode_i = 1'b0;
    logic [W-1:0] fix_dly_i = '0;
    logic [W-1:0] var_dly_i = '0;
    logic [W-1:0] min_dly_i = '0;
    logic         edge_sel_i = 1'b1;
    logic         safe_lvl_i = 1'b0;
    logic         trip_i = 1'b0;
    logic         run_i = 1'b0;
    logic         gate_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_turnon_delay dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_i      (pwm_i),
        .var_mode_i (var_mode_i),
        .fix_dly_i  (fix_dly_i),
        .var_dly_i  (var_dly_i),
        .min_dly_i  (min_dly_i),
        .edge_sel_i (edge_sel_i),
        .safe_lvl_i (safe_lvl_i),
        .trip_i     (trip_i),
        .run_i      (run_i),
        .gate_o     (gate_o)
    );

    task automatic chk(input string req, input logic exp);
        checks++;
        if (gate_o !== exp) begin
            errors++;
            $display("FAIL %s gate_o actual %b expected %b at %0t", req, gate_o, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Applies the new level to pwm_i. The gate must hold until d edges have
    // passed and change at edge d+1 (counted from the drive point).
    task automatic delayed_edge(input string req, input logic lvl, input int d);
        logic old;
        old   = gate_o;
        pwm_i = lvl;
        if (d > 0) begin
            step(d);
            chk(req, old);
        end
        step(1);
        chk(req, lvl);
    endtask

    task automatic t_reset;
        safe_lvl_i = 1'b1;
        #1 chk("R1", 1'b1);
        safe_lvl_i = 1'b0;
        #1 chk("R1", 1'b0);
        step(2);
        rst_n = 1'b1;
        run_i = 1'b1;
        step(2);
        chk("R1", 1'b0);
    endtask

    task automatic t_rise_fixed;
        edge_sel_i = 1'b1;
        var_mode_i = 1'b0;
        fix_dly_i  = 16'd5;
        var_dly_i  = 16'd1;
        min_dly_i  = 16'd1;
        delayed_edge("R2 R5", 1'b1, 5);
        step(3);
        delayed_edge("R3", 1'b0, 0);
        step(2);
        fix_dly_i = 16'd0;
        delayed_edge("R2 zero", 1'b1, 0);
        delayed_edge("R3", 1'b0, 0);
    endtask

    task automatic t_fall_sel;
        edge_sel_i = 1'b0;
        fix_dly_i  = 16'd4;
        step(2);
        delayed_edge("R4 rise", 1'b1, 0);
        step(2);
        delayed_edge("R4 fall", 1'b0, 4);
        edge_sel_i = 1'b1;
        step(1);
    endtask

    task automatic t_var;
        var_mode_i = 1'b1;
        fix_dly_i  = 16'd1;
        var_dly_i  = 16'd2;
        min_dly_i  = 16'd6;
        delayed_edge("R6 clamp", 1'b1, 6);
        delayed_edge("R3", 1'b0, 0);
        var_dly_i = 16'd9;
        min_dly_i = 16'd3;
        delayed_edge("R6 above", 1'b1, 9);
        delayed_edge("R3", 1'b0, 0);
        var_mode_i = 1'b0;
    endtask

    task automatic t_cancel;
        bit seen;
        fix_dly_i = 16'd8;
        pwm_i = 1'b1;
        step(3);
        pwm_i = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            step(1);
            if (gate_o !== 1'b0) seen = 1'b1;
        end
        checks++;
        if (seen) begin
            errors++;
            $display("FAIL R7 gate pulsed actual 1 expected 0");
        end
        chk("R7", 1'b0);
    endtask

    task automatic t_trip;
        fix_dly_i = 16'd5;
        delayed_edge("R2", 1'b1, 5);
        trip_i = 1'b1;
        safe_lvl_i = 1'b0;
        step(1);
        chk("R8", 1'b0);
        edge_sel_i = 1'b0;
        step(4);
        chk("R8 hold", 1'b0);
        safe_lvl_i = 1'b1;
        step(1);
        chk("R8 level", 1'b1);
        safe_lvl_i = 1'b0;
        edge_sel_i = 1'b1;
        step(1);
        chk("R8", 1'b0);
        trip_i = 1'b0;
        step(5);
        chk("R10 full delay", 1'b0);
        step(1);
        chk("R10 full delay", 1'b1);
    endtask

    task automatic t_run;
        safe_lvl_i = 1'b1;
        run_i = 1'b0;
        pwm_i = 1'b0;
        step(1);
        chk("R9", 1'b1);
        step(3);
        chk("R9 hold", 1'b1);
        run_i = 1'b1;
        step(1);
        chk("R10 pass", 1'b0);
        safe_lvl_i = 1'b0;
        step(2);
        chk("R10", 1'b0);
    endtask

    initial begin
        t_reset();
        t_rise_fixed();
        t_fall_sel();
        t_var();
        t_cancel();
        t_trip();
        t_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule